// File: doc/BRIEF.md
# Complementary PWM Pair with Dead-Time Insertion

This block turns a single PWM reference waveform into two complementary drive outputs, A and A-prime (called B in the port names). Each time the reference changes level, the output that is switching off drops at once. The output that is switching on waits for a programmable number of prescaled count ticks. This keeps the two drives from being active together during a changeover. Each transition direction has its own 8-bit gap, so rising and falling changeovers can be tuned separately.

After the dead-time logic, each output passes through a polarity stage. Output A can also be forced to its inactive level by an active-low enable. The reference generator, the count prescaler and any register access sit outside this block. It only needs the reference level, a one-cycle tick strobe and its static configuration inputs.

Top module: `comp_pwm_deadband`

## Requirements
- R1: On a rising reference level, the A-prime drive becomes inactive at once. The outputs are registered, so a reference change sampled at one clock edge shows on the pins after the following edge.
- R2: On a falling reference level, the A drive becomes inactive at once, with the same two-edge latency as R1.
- R3: After a rising reference, A becomes active once the high gap `gap_i[15:8]` has elapsed, measured in ticks. The first tick counted is the one sampled at the edge after the reference change is seen. With a tick on every cycle, A rises on the pins gap+2 clock edges after the reference is driven.
- R4: After a falling reference, A-prime becomes active once the low gap `gap_i[7:0]` has elapsed, counted in ticks the same way as R3.
- R5: A gap value of 0 gives plain complementary switching. The incoming output turns on at the same edge as the outgoing one turns off.
- R6: If the reference changes again before a gap has run out, the pending turn-on is cancelled. The two drives are never active at the same time.
- R7: Polarity bit 0 means active high. Polarity bit 1 means active low, so the output pin is the inverted drive. `pol_a_i` applies to A and `pol_b_i` to A-prime, each on its own.
- R8: When `a_off_i` is 1, output A sits at its inactive level, which equals `pol_a_i`. A value of 0 lets A follow its drive. A-prime is not affected by `a_off_i`.
- R9: While `rst` is high, both output pins are 0. The first reference level sampled after reset is taken as a fresh edge, so the matching output turns on after its gap.
- R10: Gaps advance only on cycles where `tick_i` is 1. With no ticks, a pending turn-on waits forever.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescaled count tick, one cycle wide |
| ref_i | input | 1 | PWM reference level |
| gap_i | input | 16 | Gaps: [7:0] low gap (A off to A-prime on), [15:8] high gap (A-prime off to A on) |
| pol_a_i | input | 1 | Polarity of A (1 = active low) |
| pol_b_i | input | 1 | Polarity of A-prime (1 = active low) |
| a_off_i | input | 1 | Output A disable (1 = forced inactive) |
| out_a_o | output | 1 | Output A |
| out_b_o | output | 1 | Output A-prime |

## Verification
The sharpest collision is a reference edge that arrives in the same cycle as the tick that would end the pending gap. The new edge must win, so the old turn-on is dropped and a new gap starts. The bench provokes this by toggling the reference at random with short gaps and a tick on most cycles. It also runs a directed case that toggles exactly at gap expiry. Every cycle, the pins are compared against a reference model written from the requirements, and the bench also checks that the two drives are never active together.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  // which output is waiting for its gap to run out
  typedef enum logic {
    WAIT_B = 1'b0,
    WAIT_A = 1'b1
  } wait_e;

  function automatic logic to_pin(input logic active, input logic invert);
    return active ^ invert;
  endfunction
endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [GAP_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expire_o
);
  localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // a fresh load cancels whatever was about to expire
  assign expire_o = !load_i && tick_i && (cnt_q == ONE);
endmodule

// File: rtl/edge_seq.sv
module edge_seq
  import dtp_pkg::*;
#(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic             tick_i,
  input  logic [GAP_W-1:0] gap_lo_i,
  input  logic [GAP_W-1:0] gap_hi_i,
  output logic             act_a_o,
  output logic             act_b_o
);
  logic  ref_q, seen_q, edge_w;
  wait_e wait_q;
  logic  act_a_q, act_b_q;
  logic  [GAP_W-1:0] gap_sel;
  logic  gap_zero, expire;

  assign edge_w   = !seen_q || (ref_i != ref_q);
  assign gap_sel  = ref_i ? gap_hi_i : gap_lo_i;
  assign gap_zero = (gap_sel == '0);

  gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (edge_w),
    .load_val_i (gap_sel),
    .tick_i     (tick_i),
    .expire_o   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q   <= 1'b0;
      seen_q  <= 1'b0;
      wait_q  <= WAIT_B;
      act_a_q <= 1'b0;
      act_b_q <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      ref_q  <= ref_i;
      if (edge_w) begin
        wait_q <= ref_i ? WAIT_A : WAIT_B;
        if (ref_i) begin
          act_b_q <= 1'b0;
          act_a_q <= gap_zero;
        end else begin
          act_a_q <= 1'b0;
          act_b_q <= gap_zero;
        end
      end else if (expire) begin
        if (wait_q == WAIT_A) act_a_q <= 1'b1;
        else                  act_b_q <= 1'b1;
      end
    end
  end

  assign act_a_o = act_a_q;
  assign act_b_o = act_b_q;
endmodule

// File: rtl/out_stage.sv
module out_stage
  import dtp_pkg::*;
#(
  parameter int N_OUT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] act_i,
  input  logic [N_OUT-1:0] inv_i,
  input  logic [N_OUT-1:0] kill_i,
  output logic [N_OUT-1:0] pin_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_ch
    logic pin_q;
    always_ff @(posedge clk) begin
      if (rst)            pin_q <= 1'b0;
      else if (kill_i[g]) pin_q <= inv_i[g];
      else                pin_q <= to_pin(act_i[g], inv_i[g]);
    end
    assign pin_o[g] = pin_q;
  end
endmodule

// File: rtl/comp_pwm_deadband.sv
module comp_pwm_deadband #(
  parameter int GAP_W = 8,
  localparam int WORD_W = 2 * GAP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              ref_i,
  input  logic [WORD_W-1:0] gap_i,
  input  logic              pol_a_i,
  input  logic              pol_b_i,
  input  logic              a_off_i,
  output logic              out_a_o,
  output logic              out_b_o
);
  logic       act_a, act_b;
  logic [1:0] pins;

  edge_seq #(.GAP_W(GAP_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ref_i    (ref_i),
    .tick_i   (tick_i),
    .gap_lo_i (gap_i[GAP_W-1:0]),
    .gap_hi_i (gap_i[WORD_W-1:GAP_W]),
    .act_a_o  (act_a),
    .act_b_o  (act_b)
  );

  out_stage #(.N_OUT(2)) u_out (
    .clk    (clk),
    .rst    (rst),
    .act_i  ({act_b, act_a}),
    .inv_i  ({pol_b_i, pol_a_i}),
    .kill_i ({1'b0, a_off_i}),
    .pin_o  (pins)
  );

  assign out_a_o = pins[0];
  assign out_b_o = pins[1];
endmodule

// File: rtl/dtp_chk.sv
module dtp_chk #(
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_i,
  input logic [2*GAP_W-1:0] gap_i,
  input logic             pol_a_i,
  input logic             a_off_i,
  input logic             act_a,
  input logic             act_b,
  input logic             out_a_o,
  input logic             out_b_o
);
  // R6
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(act_a && act_b));
  // R1
  rise_drops_b_chk: assert property (@(posedge clk) disable iff (rst) $rose(ref_i) |=> !act_b);
  // R2
  fall_drops_a_chk: assert property (@(posedge clk) disable iff (rst) $fell(ref_i) |=> !act_a);
  // R5
  zero_gap_a_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(ref_i) && gap_i[2*GAP_W-1:GAP_W] == '0) |=> act_a);
  // R8
  a_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    a_off_i |=> (out_a_o == $past(pol_a_i)));
  // R9
  reset_low_chk: assert property (@(posedge clk) rst |=> (!out_a_o && !out_b_o));
endmodule

bind comp_pwm_deadband dtp_chk #(.GAP_W(GAP_W)) u_chk (
  .clk(clk), .rst(rst), .ref_i(ref_i), .gap_i(gap_i), .pol_a_i(pol_a_i),
  .a_off_i(a_off_i), .act_a(act_a), .act_b(act_b),
  .out_a_o(out_a_o), .out_b_o(out_b_o)
);

// File: tb/comp_pwm_deadband_tb.sv
module comp_pwm_deadband_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b1, ref_l = 1'b0, pol_a = 1'b0, pol_b = 1'b0, a_off = 1'b0;
  logic [15:0] gap = 16'h0;
  logic out_a, out_b;
  int checks = 0, errors = 0;
  bit  model_on = 1'b0;

  always #5 clk = ~clk;

  comp_pwm_deadband dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .ref_i(ref_l), .gap_i(gap),
    .pol_a_i(pol_a), .pol_b_i(pol_b), .a_off_i(a_off),
    .out_a_o(out_a), .out_b_o(out_b)
  );

  // reference model from the requirements
  logic m_a, m_b, m_seen, m_q, m_dir, e_a, e_b;
  logic [7:0] m_cnt;
  always @(posedge clk) begin
    if (rst) begin
      m_a <= 0; m_b <= 0; m_seen <= 0; m_q <= 0; m_dir <= 0; m_cnt <= 0;
      e_a <= 0; e_b <= 0;
    end else begin
      m_seen <= 1; m_q <= ref_l;
      if (!m_seen || ref_l != m_q) begin
        m_dir <= ref_l;
        if (ref_l) begin m_b <= 0; m_a <= (gap[15:8] == 0); m_cnt <= gap[15:8]; end
        else       begin m_a <= 0; m_b <= (gap[7:0] == 0);  m_cnt <= gap[7:0];  end
      end else if (tick && m_cnt != 0) begin
        m_cnt <= m_cnt - 8'd1;
        if (m_cnt == 8'd1) begin
          if (m_dir) m_a <= 1; else m_b <= 1;
        end
      end
      e_a <= a_off ? pol_a : (m_a ^ pol_a);
      e_b <= m_b ^ pol_b;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk(out_a == e_a, "R3 R7 R8 model A", out_a, e_a);
      chk(out_b == e_b, "R4 R7 model B", out_b, e_b);
      chk(!(m_a && m_b), "R6 overlap", m_a, m_b);
    end
  end

  // drive ref at a negedge, count rising edges until A (active high) is seen
  task automatic measure_a(input logic [7:0] g, input string tag);
    int n = 0;
    ref_l = 1'b0; repeat (g + 6) @(negedge clk);
    gap[15:8] = g; ref_l = 1'b1;
    while (out_a !== 1'b1 && n < 300) begin @(posedge clk); n++; @(negedge clk); end
    chk(n == g + 2, tag, n, g + 2);
  endtask

  task automatic measure_b(input logic [7:0] g, input string tag);
    int n = 0;
    ref_l = 1'b1; repeat (g + 6) @(negedge clk);
    gap[7:0] = g; ref_l = 1'b0;
    while (out_b !== 1'b1 && n < 300) begin @(posedge clk); n++; @(negedge clk); end
    chk(n == g + 2, tag, n, g + 2);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk(out_a == 0 && out_b == 0, "R9 reset outputs", {out_a, out_b}, 0);
    gap = 16'h0303;
    rst = 1'b0; model_on = 1'b1;
    // R9: ref low at release is a fresh edge, B rises after 3 ticks
    repeat (6) @(negedge clk);
    chk(out_b == 1 && out_a == 0, "R9 first level as edge", {out_a, out_b}, 1);

    measure_a(8'd5, "R3 high gap 5");
    measure_b(8'd7, "R4 low gap 7");
    measure_a(8'd0, "R5 zero high gap");
    measure_b(8'd0, "R5 zero low gap");
    measure_a(8'd255, "R3 high gap 255");

    // R1: rising ref drops A-prime two edges later
    gap = 16'h0A0A; ref_l = 0; repeat (20) @(negedge clk);
    ref_l = 1; @(negedge clk); @(negedge clk);
    chk(out_b == 0, "R1 A-prime off", out_b, 0);
    // R6: toggle back before gap ends, A must never come on
    ref_l = 0; repeat (3) @(negedge clk);
    chk(out_a == 0, "R6 cancelled A", out_a, 0);
    // R2: fall drops A
    repeat (20) @(negedge clk); ref_l = 1; repeat (20) @(negedge clk);
    ref_l = 0; @(negedge clk); @(negedge clk);
    chk(out_a == 0, "R2 A off", out_a, 0);

    // R6: toggle exactly on the expiry tick (gap 2: expiry at 3rd edge)
    gap = 16'h0202; repeat (10) @(negedge clk);
    ref_l = 1; @(negedge clk); @(negedge clk); ref_l = 0;
    repeat (2) @(negedge clk);
    chk(out_a == 0, "R6 toggle at expiry", out_a, 0);

    // R10: no ticks -> A stays off
    repeat (10) @(negedge clk);
    tick = 0; ref_l = 1; repeat (50) @(negedge clk);
    chk(out_a == 0, "R10 frozen without ticks", out_a, 0);
    tick = 1; repeat (4) @(negedge clk);
    chk(out_a == 1, "R10 resumes with ticks", out_a, 1);

    // R7: polarity inversion
    pol_a = 1; pol_b = 1; repeat (2) @(negedge clk);
    chk(out_a == 0 && out_b == 1, "R7 active-low pins", {out_a, out_b}, 1);
    // R8: disable A -> inactive level = pol_a, B unaffected
    a_off = 1; repeat (2) @(negedge clk);
    chk(out_a == 1, "R8 A forced inactive", out_a, 1);
    chk(out_b == 1, "R8 B untouched", out_b, 1);
    a_off = 0; pol_a = 0; pol_b = 0;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 5) == 0) ref_l = ~ref_l;
      tick = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 60) == 0) gap = {8'($urandom_range(0, 6)), 8'($urandom_range(0, 6))};
      if ($urandom_range(0, 200) == 0) pol_a = ~pol_a;
      if ($urandom_range(0, 200) == 0) pol_b = ~pol_b;
      if ($urandom_range(0, 100) == 0) a_off = ~a_off;
    end
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule